// File: doc/BRIEF.md
# Key FIFO and Sensor RAM

This block is the input-side store of a keyboard and display controller. An upstream scanner hands it entries over a push interface. In scanned keyboard mode, eight storage slots form a first-in first-out queue of key codes. In sensor matrix mode, the same eight slots form a row-addressed image of the sensor matrix, one byte per row.

The CPU side uses three things. A command port selects the read row and the autoincrement flag, clears the queue, and ends an interrupt. A read strobe returns one byte. A status byte reports the entry count, a full flag, overrun and underrun errors, a sensor/error flag and the display-unavailable flag. An interrupt line tells the CPU that data is waiting.

The push side is a valid/ready stream with `in_ready` held high at all times, so the block never applies back-pressure. A push that arrives in keyboard mode while the queue is full is accepted and then dropped, and the drop is recorded as an overrun. `mode_sensor` is a static setting. Change it only together with a clear command.

Top module: `kbd_fifo_sense`

## Requirements
- R1: In keyboard mode (`mode_sensor`=0), reads return stored entries in push order. The row field and autoincrement field of a read command have no effect on what is returned.
- R2: Status bits [2:0] hold the entry count modulo 8 and bit 3 is set when 8 entries are held. A full queue therefore reads 0x08.
- R3: `in_ready` is always 1. A keyboard push into a full queue, with no read in the same cycle, is dropped, leaves the count at 8 and sets overrun (status bit 5).
- R4: A keyboard read of an empty queue sets underrun (status bit 4), returns 0x00 and leaves the count at 0.
- R5: In keyboard mode `irq` is 1 exactly when the queue holds at least one entry.
- R6: A read command is a command byte with bits [7:5]=010. Its bits [2:0] load the sensor row pointer and its bit 4 sets autoincrement. In sensor mode each read returns the addressed row. With autoincrement the pointer then advances, wrapping from 7 to 0. Without autoincrement it stays.
- R7: In sensor mode, a push whose byte differs from the stored row marks a change. The next `scan_end` pulse raises `irq`. A `scan_end` with no change since the last one leaves `irq` low.
- R8: In sensor mode a read with autoincrement 0 drops `irq`. With autoincrement 1, reads leave `irq` high until an end-interrupt command (bits [7:5]=111) is given.
- R9: In sensor mode, status bit 6 is 1 while any row holds a nonzero byte.
- R10: The end-interrupt command's bit 4 sets error mode. In keyboard mode with error mode on, a `dbl_key` pulse sets status bit 6. With error mode off, the pulse has no effect.
- R11: A clear command (bits [7:5]=110 with bit 1 or bit 0 set) does the following: empties the queue, zeroes the storage, clears overrun, underrun and the error flag, drops `irq`, and resets the row pointer to 0.
- R12: Overrun, underrun and the error flag stay set until a clear command.
- R13: Status bit 7 follows `disp_busy`.
- R14: After reset the status is 0x00 (with `disp_busy` low), `irq` is 0 and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sensor | input | 1 | 0 = keyboard queue, 1 = sensor matrix RAM |
| in_valid | input | 1 | Push valid |
| in_ready | output | 1 | Push ready, always 1 |
| in_data | input | 8 | Key code or sensor row byte |
| in_row | input | 3 | Sensor row for a push in sensor mode |
| scan_end | input | 1 | Pulse at the end of a matrix scan |
| dbl_key | input | 1 | Pulse: two keys closed within one debounce interval |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_data | input | 8 | Command byte |
| rd_req | input | 1 | Data read strobe |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_req` |
| rd_data | output | 8 | Read data |
| disp_busy | input | 1 | Display RAM unavailable flag |
| status | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
Status bits and `irq` follow registered state, so they change one clock after the push, read, command or pulse that causes them. Status bit 7 follows `disp_busy` in the same cycle. Read data and `rd_valid` come from a register loaded at the edge where `rd_req` is sampled. The bench drives every input just after a rising edge, holds it for exactly one edge, and samples all outputs one time unit after that edge. Each expected value is therefore read in the first cycle it is due.

// File: rtl/kfs_pkg.sv
package kfs_pkg;
  localparam int KFS_DW    = 8;
  localparam int KFS_DEPTH = 8;

  typedef enum logic [2:0] {
    OPC_READ  = 3'b010,
    OPC_CLEAR = 3'b110,
    OPC_EOI   = 3'b111
  } kfs_opc_e;

  // Bit positions inside command bytes
  localparam int CMD_AI_BIT  = 4;
  localparam int CMD_E_BIT   = 4;
  localparam int CMD_CF_BIT  = 1;
  localparam int CMD_CA_BIT  = 0;

  // Status byte layout
  localparam int ST_FULL = 3;
  localparam int ST_UNR  = 4;
  localparam int ST_OVR  = 5;
  localparam int ST_SE   = 6;
  localparam int ST_DU   = 7;
endpackage

// File: rtl/kfs_cmd.sv
module kfs_cmd #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_data,
  output logic          rd_cmd,
  output logic [AW-1:0] rd_row,
  output logic          clr,
  output logic          eoi,
  output logic          ai_q,
  output logic          emode_q
);
  import kfs_pkg::*;

  logic [2:0] opc;
  assign opc    = cmd_data[7:5];
  assign rd_cmd = cmd_valid && (opc == OPC_READ);
  assign clr    = cmd_valid && (opc == OPC_CLEAR) &&
                  (cmd_data[CMD_CF_BIT] || cmd_data[CMD_CA_BIT]);
  assign eoi    = cmd_valid && (opc == OPC_EOI);
  assign rd_row = cmd_data[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ai_q    <= 1'b0;
      emode_q <= 1'b0;
    end else begin
      if (rd_cmd) ai_q    <= cmd_data[CMD_AI_BIT];
      if (eoi)    emode_q <= cmd_data[CMD_E_BIT];
    end
  end

  // R6: a read command latches its autoincrement bit
  a_r6_ai_latch: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> ai_q == $past(cmd_data[CMD_AI_BIT]));
endmodule

// File: rtl/kfs_store.sv
module kfs_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] wcur,
  output logic          any_set
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] nz;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n || wipe)               mem[i] <= '0;
      else if (we && waddr == AW'(i))   mem[i] <= wdata;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_nz
    assign nz[g] = |mem[g];
  end

  assign any_set = |nz;
  assign rdata   = mem[raddr];
  assign wcur    = mem[waddr];
endmodule

// File: rtl/kfs_ctrl.sv
module kfs_ctrl #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sensor,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic [AW-1:0] push_row,
  input  logic          pop,
  input  logic          scan_end,
  input  logic          dbl_key,
  input  logic          rd_cmd,
  input  logic [AW-1:0] rd_row,
  input  logic          clr,
  input  logic          eoi,
  input  logic          ai,
  input  logic          emode,
  input  logic [DW-1:0] st_rdata,
  input  logic [DW-1:0] st_wcur,
  output logic          st_we,
  output logic [AW-1:0] st_waddr,
  output logic [AW-1:0] st_raddr,
  output logic [AW:0]   cnt,
  output logic          ovr,
  output logic          unr,
  output logic          err,
  output logic          sirq,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);

  logic [AW-1:0] wptr, rptr, sptr;
  logic          pend;
  logic          kb, kb_full, kb_empty, do_push, do_pop, chg;

  assign kb       = !sensor;
  assign kb_full  = (cnt == FULLV);
  assign kb_empty = (cnt == '0);
  assign do_push  = kb && push && (!kb_full || pop);
  assign do_pop   = kb && pop && !kb_empty;
  assign chg      = sensor && push && (push_data != st_wcur);

  assign st_we    = kb ? do_push : (sensor && push);
  assign st_waddr = kb ? wptr : push_row;
  assign st_raddr = kb ? rptr : sptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; sptr <= '0; cnt <= '0;
      ovr <= 1'b0; unr <= 1'b0; err <= 1'b0;
      sirq <= 1'b0; pend <= 1'b0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else if (clr) begin
      wptr <= '0; rptr <= '0; sptr <= '0; cnt <= '0;
      ovr <= 1'b0; unr <= 1'b0; err <= 1'b0;
      sirq <= 1'b0; pend <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      // keyboard queue
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      if (kb && push && kb_full && !pop) ovr <= 1'b1;
      if (kb && pop && kb_empty)         unr <= 1'b1;
      if (kb && emode && dbl_key)        err <= 1'b1;

      // read data path
      rd_valid <= pop;
      if (pop) rd_data <= (kb && kb_empty) ? '0 : st_rdata;

      // sensor row pointer
      if (rd_cmd)                   sptr <= rd_row;
      else if (sensor && pop && ai) sptr <= sptr + 1'b1;

      // sensor change tracking and interrupt
      if (sensor && scan_end) pend <= chg;
      else if (chg)           pend <= 1'b1;

      if (sensor && scan_end && pend)     sirq <= 1'b1;
      else if (eoi)                       sirq <= 1'b0;
      else if (sensor && pop && !ai)      sirq <= 1'b0;
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULLV);

  a_r3_drop_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    kb && push && kb_full && !pop && !clr |=> cnt == FULLV && ovr);

  a_r4_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    kb && pop && kb_empty && !push && !clr |=> cnt == '0 && unr && rd_data == '0);

  a_r6_ai_step: assert property (@(posedge clk) disable iff (!rst_n)
    sensor && pop && ai && !rd_cmd && !clr |=> sptr == $past(sptr) + 1'b1);

  a_r8_ai_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sensor && sirq && ai && pop && !eoi && !clr |=> sirq);

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0 && !ovr && !unr && !err && !sirq && sptr == '0);

  a_r12_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !clr |=> ovr);

  a_r12_unr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unr && !clr |=> unr);
endmodule

// File: rtl/kbd_fifo_sense.sv
module kbd_fifo_sense #(
  parameter int DW    = kfs_pkg::KFS_DW,
  parameter int DEPTH = kfs_pkg::KFS_DEPTH,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sensor,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [AW-1:0] in_row,
  input  logic          scan_end,
  input  logic          dbl_key,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_data,
  input  logic          rd_req,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          disp_busy,
  output logic [7:0]    status,
  output logic          irq
);
  import kfs_pkg::*;

  logic          rd_cmd, clr, eoi, ai_q, emode_q;
  logic [AW-1:0] rd_row, st_waddr, st_raddr;
  logic          st_we, any_set;
  logic [DW-1:0] st_rdata, st_wcur;
  logic [AW:0]   cnt;
  logic          ovr, unr, err, sirq;

  assign in_ready = 1'b1;

  kfs_cmd #(.AW(AW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .rd_cmd(rd_cmd), .rd_row(rd_row), .clr(clr), .eoi(eoi),
    .ai_q(ai_q), .emode_q(emode_q)
  );

  kfs_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wipe(clr), .we(st_we), .waddr(st_waddr),
    .wdata(in_data), .raddr(st_raddr), .rdata(st_rdata), .wcur(st_wcur),
    .any_set(any_set)
  );

  kfs_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sensor(mode_sensor),
    .push(in_valid && in_ready), .push_data(in_data), .push_row(in_row),
    .pop(rd_req), .scan_end(scan_end), .dbl_key(dbl_key),
    .rd_cmd(rd_cmd), .rd_row(rd_row), .clr(clr), .eoi(eoi),
    .ai(ai_q), .emode(emode_q), .st_rdata(st_rdata), .st_wcur(st_wcur),
    .st_we(st_we), .st_waddr(st_waddr), .st_raddr(st_raddr),
    .cnt(cnt), .ovr(ovr), .unr(unr), .err(err), .sirq(sirq),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_comb begin
    status          = '0;
    status[2:0]     = 3'(cnt);
    status[ST_FULL] = cnt[AW];
    status[ST_UNR]  = unr;
    status[ST_OVR]  = ovr;
    status[ST_SE]   = mode_sensor ? any_set : err;
    status[ST_DU]   = disp_busy;
  end

  assign irq = mode_sensor ? sirq : (cnt != '0);

  // R5: keyboard interrupt tracks a non-empty queue
  a_r5_kb_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sensor && $past(!mode_sensor) && $rose(irq) |-> $past(status[3:0] == 4'h0));
endmodule

// File: tb/tb_kbd_fifo_sense.sv
module tb_kbd_fifo_sense;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_sensor = 1'b0, in_valid = 1'b0, scan_end = 1'b0, dbl_key = 1'b0;
  logic cmd_valid = 1'b0, rd_req = 1'b0, disp_busy = 1'b0;
  logic [7:0] in_data = '0, cmd_data = '0;
  logic [2:0] in_row = '0;
  logic in_ready, rd_valid, irq;
  logic [7:0] rd_data, status;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_fifo_sense dut (
    .clk(clk), .rst_n(rst_n), .mode_sensor(mode_sensor),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_row(in_row),
    .scan_end(scan_end), .dbl_key(dbl_key), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .disp_busy(disp_busy), .status(status), .irq(irq)
  );

  // bit 8: 1 = read and compare with [7:0], 0 = push [7:0]
  localparam logic [8:0] VEC [8] = '{
    9'h011, 9'h022, 9'h033, 9'h111, 9'h044, 9'h122, 9'h133, 9'h144
  };

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] r);
    in_valid = 1'b1; in_data = d; in_row = r; step(); in_valid = 1'b0;
  endtask
  task automatic cmd(input logic [7:0] c);
    cmd_valid = 1'b1; cmd_data = c; step(); cmd_valid = 1'b0;
  endtask
  task automatic rd(); rd_req = 1'b1; step(); rd_req = 1'b0; endtask
  task automatic scan(); scan_end = 1'b1; step(); scan_end = 1'b0; endtask
  task automatic dbl(); dbl_key = 1'b1; step(); dbl_key = 1'b0; endtask

  task automatic rd_exp(input logic [7:0] e, input string tag);
    rd();
    chk(rd_valid && rd_data == e, tag, rd_data, e);
  endtask
  task automatic st_exp(input logic [7:0] e, input string tag);
    chk(status == e, tag, status, e);
  endtask
  task automatic irq_exp(input logic e, input string tag);
    chk(irq == e, tag, {7'd0, irq}, {7'd0, e});
  endtask

  initial begin
    repeat (3) step();
    chk(status == 8'h00 && !irq && !rd_valid, "R14 reset state", status, 8'h00);
    rst_n = 1'b1;
    step();

    // R1 ordered queue, table driven
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][8]) rd_exp(VEC[i][7:0], "R1 order");
      else           push(VEC[i][7:0], 3'd0);
    end
    st_exp(8'h00, "R2 empty after table");

    // R1 read-command fields ignored in keyboard mode
    cmd(8'h57);
    push(8'hAA, 3'd5);
    rd_exp(8'hAA, "R1 fields ignored");

    // R2/R3/R5 full and overrun
    for (int i = 1; i <= 8; i++) push(8'(i), 3'd0);
    st_exp(8'h08, "R2 full status");
    irq_exp(1'b1, "R5 irq with data");
    chk(in_ready, "R3 ready high", {7'd0, in_ready}, 8'h01);
    push(8'h99, 3'd0);
    st_exp(8'h28, "R3 overrun");
    for (int i = 1; i <= 8; i++) rd_exp(8'(i), "R3 dropped entry absent");
    st_exp(8'h20, "R12 overrun sticky");
    irq_exp(1'b0, "R5 irq empty");

    // R4 underrun
    rd_exp(8'h00, "R4 underrun data");
    st_exp(8'h30, "R4 underrun flag");

    // R11 clear via CF
    cmd(8'hC2);
    st_exp(8'h00, "R11 clear flags");

    // R10 error mode
    dbl();
    st_exp(8'h00, "R10 E off ignored");
    cmd(8'hF0);
    dbl();
    st_exp(8'h40, "R10 error flag");
    cmd(8'hC1);
    st_exp(8'h00, "R11 clear-all");

    // R13
    disp_busy = 1'b1; #1;
    st_exp(8'h80, "R13 busy bit");
    disp_busy = 1'b0;

    // sensor mode
    mode_sensor = 1'b1;
    step();
    st_exp(8'h00, "R9 no closure");
    push(8'h05, 3'd3);
    irq_exp(1'b0, "R7 no irq before scan end");
    st_exp(8'h40, "R9 closure flag");
    scan();
    irq_exp(1'b1, "R7 irq at scan end");
    cmd(8'h43);
    rd_exp(8'h05, "R6 row read");
    irq_exp(1'b0, "R8 read clears irq");
    rd_exp(8'h05, "R6 no advance without AI");

    push(8'h09, 3'd4);
    scan();
    cmd(8'h53);
    rd_exp(8'h05, "R6 AI row3");
    rd_exp(8'h09, "R6 AI row4");
    irq_exp(1'b1, "R8 irq held with AI");
    cmd(8'hE0);
    irq_exp(1'b0, "R8 end-interrupt clears");

    push(8'h77, 3'd7);
    push(8'h10, 3'd0);
    scan();
    cmd(8'hE0);
    push(8'h10, 3'd0);
    scan();
    irq_exp(1'b0, "R7 unchanged value no irq");
    cmd(8'h57);
    rd_exp(8'h77, "R6 AI row7");
    rd_exp(8'h10, "R6 AI wrap to row0");

    cmd(8'h55);
    cmd(8'hC2);
    st_exp(8'h00, "R11 storage zeroed");
    push(8'h3C, 3'd0);
    rd_exp(8'h3C, "R11 row pointer reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule